// File: doc/BRIEF.md
# V86 Linear Address Generator

This block turns a segment:offset pair from a task in 8086-emulation mode into a physical address. The segment value is shifted left by four bits and added to the offset, exactly as real-mode segmentation does. Every segment has a fixed 64 KB limit, so an offset wider than 16 bits is refused with a limit fault.

When paging is off, the 21-bit linear result goes out unchanged as the physical address. The task is then confined to the low megabyte, plus the small region reached by the carry. When paging is on, a 256-entry table of 4 KB page frames relocates the one-megabyte window anywhere in a 32-bit physical space. This allows several emulated tasks to sit at different physical locations. A table entry that is not present produces a page fault in place of the valid strobe.

All results are registered and appear one clock after the request.

Top module: `v86_addr_gen`

## Requirements
- R1: The linear address is (seg_i × 16) + off_i, computed to 21 bits, so segment FFFFh plus offset FFFFh gives 10FFEFh.
- R2: A request with off_i greater than FFFFh (bit 16 set) raises limit_fault_o one cycle later, with valid_o and page_fault_o low, whatever the state of pg_en_i.
- R3: With pg_en_i low, a legal request raises valid_o one cycle later, with paddr_o equal to the 21-bit linear address zero-extended to 32 bits.
- R4: With pg_en_i high and linear bit 20 clear, the table entry at index linear[19:12] is looked up. If that entry is present, valid_o rises and paddr_o = {entry frame[19:0], linear[11:0]}.
- R5: With pg_en_i high, linear bit 20 clear and the selected entry not present, page_fault_o rises one cycle later and valid_o stays low.
- R6: With pg_en_i high and linear bit 20 set (the carry region), the address passes through untranslated (paddr_o equals the linear address) with valid_o high, even if the entry at linear[19:12] is absent.
- R7: A table write (tbl_we_i with tbl_idx_i, tbl_pfn_i, tbl_present_i) takes effect for requests in later cycles. A request in the same cycle as the write sees the old entry. Reset clears every present bit.
- R8: After reset, and in any cycle following one where req_i or v86_i was low, valid_o, limit_fault_o and page_fault_o are all low.
- R9: At most one of valid_o, limit_fault_o and page_fault_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request strobe |
| v86_i | input | 1 | Task is in 8086-emulation mode; requests without it are dropped |
| pg_en_i | input | 1 | Paging enable |
| seg_i | input | 16 | Segment register value |
| off_i | input | 17 | Effective offset, bit 16 is the overflow of the offset computation |
| tbl_we_i | input | 1 | Page table write enable |
| tbl_idx_i | input | 8 | Page table entry index to write |
| tbl_pfn_i | input | 20 | Physical frame number to write |
| tbl_present_i | input | 1 | Present bit to write |
| paddr_o | output | 32 | Physical address, registered |
| valid_o | output | 1 | paddr_o is valid for the previous request |
| limit_fault_o | output | 1 | Previous request exceeded the 64 KB limit |
| page_fault_o | output | 1 | Previous request hit a non-present page |

## Verification
The hardest case to reach is the carry region with paging on. Only segments near FFFFh with large offsets push linear bit 20 high. To show that translation is bypassed there, the entry at the same index must be absent. The table is therefore loaded so that every seventh entry, including index 0Fh, is non-present. The sweep then crosses high segment values with offsets near FFFFh, so carry-region requests land on both present and absent entries. A write issued in the same cycle as a request to that entry is also used, to separate old table contents from new.

// File: rtl/v86_agen_pkg.sv
package v86_agen_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 17;
  localparam int SHIFT   = 4;
  localparam int LIN_W   = SEG_W + SHIFT + 1;
  localparam int PA_W    = 32;
  localparam int PG_BITS = 12;
  localparam int IDX_W   = LIN_W - 1 - PG_BITS;
  localparam int PFN_W   = PA_W - PG_BITS;

  typedef struct packed {
    logic             present;
    logic [PFN_W-1:0] pfn;
  } pte_t;
endpackage

// File: rtl/v86_seg_add.sv
module v86_seg_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 17,
  parameter int SHIFT = 4,
  parameter int LIN_W = 21
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LIN_W-1:0] lin_o,
  output logic             over_o
);
  localparam logic [OFF_W-1:0] LIMIT = {1'b0, {(OFF_W-1){1'b1}}};

  assign lin_o  = LIN_W'({seg_i, {SHIFT{1'b0}}}) + LIN_W'(off_i);
  assign over_o = off_i > LIMIT;
endmodule

// File: rtl/v86_page_map.sv
module v86_page_map
  import v86_agen_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int FW = PFN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [FW-1:0] wpfn_i,
  input  logic          wpres_i,
  input  logic [IW-1:0] ridx_i,
  output logic [FW-1:0] rpfn_o,
  output logic          rpres_o
);
  localparam int DEPTH = 1 << IW;

  logic [DEPTH-1:0] pres_q;
  logic [FW-1:0]    pfn_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = we_i && (widx_i == IW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pres_q[i] <= 1'b0;
      else if (hit) pres_q[i] <= wpres_i;
    end

    always_ff @(posedge clk_i) begin
      if (hit) pfn_q[i] <= wpfn_i;
    end
  end

  assign rpfn_o  = pfn_q[ridx_i];
  assign rpres_o = pres_q[ridx_i];
endmodule

// File: rtl/v86_addr_gen.sv
module v86_addr_gen
  import v86_agen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             v86_i,
  input  logic             pg_en_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [PFN_W-1:0] tbl_pfn_i,
  input  logic             tbl_present_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             valid_o,
  output logic             limit_fault_o,
  output logic             page_fault_o
);
  logic [LIN_W-1:0] lin;
  logic             over;
  pte_t             pte;
  logic             act, carry, xlate, miss;
  logic [PA_W-1:0]  pa_nxt;
  logic             v_q, lf_q, pf_q;
  logic [PA_W-1:0]  pa_q;

  v86_seg_add #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .LIN_W(LIN_W)
  ) u_add (
    .seg_i (seg_i),
    .off_i (off_i),
    .lin_o (lin),
    .over_o(over)
  );

  v86_page_map #(.IW(IDX_W), .FW(PFN_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .widx_i (tbl_idx_i),
    .wpfn_i (tbl_pfn_i),
    .wpres_i(tbl_present_i),
    .ridx_i (lin[LIN_W-2:PG_BITS]),
    .rpfn_o (pte.pfn),
    .rpres_o(pte.present)
  );

  always_comb begin
    act    = req_i & v86_i;
    carry  = lin[LIN_W-1];
    // carry region bypasses the table
    xlate  = pg_en_i & ~carry;
    miss   = xlate & ~pte.present;
    pa_nxt = xlate ? {pte.pfn, lin[PG_BITS-1:0]} : PA_W'(lin);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= 1'b0;
      lf_q <= 1'b0;
      pf_q <= 1'b0;
      pa_q <= '0;
    end else begin
      v_q  <= act & ~over & ~miss;
      lf_q <= act & over;
      pf_q <= act & ~over & miss;
      if (act & ~over) pa_q <= pa_nxt;
    end
  end

  assign paddr_o       = pa_q;
  assign valid_o       = v_q;
  assign limit_fault_o = lf_q;
  assign page_fault_o  = pf_q;
endmodule

// File: rtl/v86_addr_gen_chk.sv
module v86_addr_gen_chk
  import v86_agen_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             v86_i,
  input logic             pg_en_i,
  input logic [SEG_W-1:0] seg_i,
  input logic [OFF_W-1:0] off_i,
  input logic [PA_W-1:0]  paddr_o,
  input logic             valid_o,
  input logic             limit_fault_o,
  input logic             page_fault_o
);
  logic [PA_W-1:0] lin_w;
  assign lin_w = PA_W'({seg_i, 4'h0}) + PA_W'(off_i);

  AST_LIMIT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && v86_i && off_i[OFF_W-1] |=> limit_fault_o && !valid_o && !page_fault_o); // R2

  AST_FLAT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && v86_i && !off_i[OFF_W-1] && !pg_en_i |=> valid_o && paddr_o == $past(lin_w)); // R3

  AST_CARRY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && v86_i && !off_i[OFF_W-1] && pg_en_i && lin_w[20] |=> valid_o && paddr_o == $past(lin_w)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && v86_i) |=> !valid_o && !limit_fault_o && !page_fault_o); // R8

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, limit_fault_o, page_fault_o})); // R9

  AST_PF_ONLY_PAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |-> $past(pg_en_i) && !$past(lin_w[20])); // R5
endmodule

bind v86_addr_gen v86_addr_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .v86_i        (v86_i),
  .pg_en_i      (pg_en_i),
  .seg_i        (seg_i),
  .off_i        (off_i),
  .paddr_o      (paddr_o),
  .valid_o      (valid_o),
  .limit_fault_o(limit_fault_o),
  .page_fault_o (page_fault_o)
);

// File: tb/v86_addr_gen_bench.sv
module v86_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, v86 = 1'b0, pg = 1'b0;
  logic [15:0] seg = '0;
  logic [16:0] off = '0;
  logic        we = 1'b0;
  logic [7:0]  widx = '0;
  logic [19:0] wpfn = '0;
  logic        wpres = 1'b0;
  logic [31:0] paddr;
  logic        valid, lfault, pfault;

  int vectors = 0;
  int misses = 0;
  logic [19:0] m_pfn [256];
  logic        m_pres [256];

  always #2 clk = ~clk;

  v86_addr_gen u_v86_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .v86_i(v86), .pg_en_i(pg),
    .seg_i(seg), .off_i(off), .tbl_we_i(we), .tbl_idx_i(widx),
    .tbl_pfn_i(wpfn), .tbl_present_i(wpres), .paddr_o(paddr),
    .valid_o(valid), .limit_fault_o(lfault), .page_fault_o(pfault)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run hung, act=timeout exp=done");
    summary();
    $finish;
  end

  task automatic check(string tag, logic ev, logic el, logic ep, logic [31:0] ea);
    vectors++;
    if (valid !== ev || lfault !== el || pfault !== ep || (ev && paddr !== ea)) begin
      misses++;
      $display("FAIL %s seg=%h off=%h pg=%0b: act v=%0b lf=%0b pf=%0b pa=%h exp v=%0b lf=%0b pf=%0b pa=%h",
               tag, seg, off, pg, valid, lfault, pfault, paddr, ev, el, ep, ea);
    end
  endtask

  // drive one request, then compare the registered result
  task automatic apply(logic r, logic v, logic p, logic [15:0] s, logic [16:0] o);
    logic [31:0] lin, ea;
    logic ev, el, ep;
    string tag;
    @(negedge clk);
    req = r; v86 = v; pg = p; seg = s; off = o;
    lin = {12'h0, s, 4'h0} + {15'h0, o};
    ev = 0; el = 0; ep = 0; ea = '0;
    if (!(r && v)) tag = "R8";
    else if (o > 17'hFFFF) begin el = 1; tag = "R2"; end
    else if (!p) begin ev = 1; ea = lin; tag = "R1/R3"; end
    else if (lin[20]) begin ev = 1; ea = lin; tag = "R6"; end
    else if (!m_pres[lin[19:12]]) begin ep = 1; tag = "R5"; end
    else begin ev = 1; ea = {m_pfn[lin[19:12]], lin[11:0]}; tag = "R4"; end
    @(negedge clk);
    req = 0;
    check(tag, ev, el, ep, ea);
  endtask

  task automatic wr(logic [7:0] i, logic [19:0] f, logic pr);
    @(negedge clk);
    we = 1; widx = i; wpfn = f; wpres = pr;
    @(negedge clk);
    we = 0;
    m_pfn[i] = f; m_pres[i] = pr;
  endtask

  function automatic logic [16:0] off_pick(int k);
    case (k)
      0: return 17'h00000;  1: return 17'h00001;  2: return 17'h00FFF;
      3: return 17'h01000;  4: return 17'h0ABCD;  5: return 17'h07FFF;
      6: return 17'h0F00F;  7: return 17'h0FFF0;  8: return 17'h0FFFF;
      9: return 17'h10000;  10: return 17'h1FFFF; default: return 17'h08421;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin m_pres[i] = 0; m_pfn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset", 0, 0, 0, '0);
    // R7: reset leaves every entry absent
    apply(1, 1, 1, 16'h0123, 17'h00456);
    apply(1, 1, 1, 16'h0000, 17'h00000);

    for (int i = 0; i < 256; i++)
      wr(8'(i), 20'(i * 4099 + 20'h3A5C1), (i % 7) != 1);

    for (int s = 0; s < 65536; s += 97)
      for (int k = 0; k < 12; k++)
        for (int p = 0; p < 2; p++)
          apply(1, 1, p[0], 16'(s), off_pick(k));

    // carry region, including absent entry 0Fh (R6)
    for (int s = 16'hFF00; s < 65536; s += 3)
      for (int k = 7; k < 11; k++)
        apply(1, 1, 1, 16'(s), off_pick(k));
    apply(1, 1, 1, 16'hFFFF, 17'h0FFFF);
    apply(1, 1, 0, 16'hFFFF, 17'h0FFFF);

    // R8: v86 low or no request
    apply(1, 0, 0, 16'h1234, 17'h00010);
    apply(1, 0, 1, 16'h1234, 17'h10000);
    apply(0, 1, 1, 16'h1234, 17'h00010);

    // R7: write and request in the same cycle see the old entry
    @(negedge clk);
    we = 1; widx = 8'h05; wpfn = 20'hBEEF1; wpres = 1;
    req = 1; v86 = 1; pg = 1; seg = 16'h0500; off = 17'h00123;
    @(negedge clk);
    we = 0; req = 0;
    check("R7 old", 1, 0, 0, {m_pfn[5], 12'h123});
    m_pfn[5] = 20'hBEEF1; m_pres[5] = 1;
    apply(1, 1, 1, 16'h0500, 17'h00123);
    wr(8'h05, 20'h00042, 0);
    apply(1, 1, 1, 16'h0500, 17'h00123);

    summary();
    $finish;
  end
endmodule